// File: doc/BRIEF.md
# Cascaded Linear Image Sensor Readout Sequencer

This block is the host-side timing source for a chain of linear image sensors that share one clock. Each sensor holds `PIX_PER_DEV` pixels. Only the first sensor in the chain gets the start pulse from this block. Every later sensor is started by the serial output of the sensor before it, so the whole chain reads out as one long line of `N_DEV * PIX_PER_DEV` pixels.

The sequencer produces the sensor clock at half the system rate. Each sensor clock has a high phase of one system cycle and then a low phase of one system cycle. The start pulse is issued once per chain frame. While a valid line is read, the block gives a global pixel index and an ADC sample strobe in the low (hold) phase of every pixel. A frame-valid flag marks the pixel clocks of real lines.

A programmable integration interval sets the frame period, and it is never allowed to fall below the period the chain physically needs. At power-up, and whenever the chain has been stopped for longer than the integration interval, the block first runs a clearing burst of dummy frames before it gives any valid line. There is no back-pressure: the sensor cannot pause, so the strobe and index are plain outputs with no ready input. Any consumer must accept one sample every two system cycles during a line.

Top module: `linarr_chain_readout`

## Requirements
- R1: While reset is held, `sns_clk`, `sns_start`, `frame_valid` and `adc_strobe` are low. The first frame after reset is always part of a clearing burst.
- R2: While a frame runs, `sns_clk` is high for one system cycle and low for the next, so one sensor clock takes two system cycles. While the block is idle, `sns_clk` stays low.
- R3: `sns_start` is high for exactly one system cycle. That cycle is the high phase of the first sensor clock of a frame, and there is one pulse per chain frame.
- R4: Start pulses of consecutive running frames are 2*P system cycles apart. P = max(`integ_period`, N_DEV*PIX_PER_DEV + 1), and it is sampled when a frame begins.
- R5: The clearing burst has INIT_FRAMES frames (12 to 15), run back to back at the minimum period. During the burst `frame_valid` and `adc_strobe` stay low. The burst always runs to its end, even if `run` drops.
- R6: If the block stays idle for more than 2*P system cycles (P taken from the current `integ_period`), the next run starts with a clearing burst. A shorter idle lets the next run start directly with a valid frame.
- R7: In a valid frame, `frame_valid` is high for the first N_DEV*PIX_PER_DEV sensor clocks. `adc_strobe` pulses once per pixel in the low phase. `pix_idx` counts 0, 1, ... N_DEV*PIX_PER_DEV-1 in order at the strobes and is 0 in the start cycle.
- R8: After the last pixel of a frame, at least one more sensor clock is issued with `frame_valid` low before the next start pulse.
- R9: When `run` is lowered, the frame in progress finishes with all its pixels. After that the block goes idle and issues no start pulse until `run` is raised again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| run | input | 1 | Run request; sampled at frame boundaries and while idle |
| integ_period | input | INTEG_W | Integration interval in sensor clocks (clamped to the minimum) |
| sns_clk | output | 1 | Common clock to all sensors of the chain |
| sns_start | output | 1 | Start pulse to the first sensor |
| frame_valid | output | 1 | High during the pixel clocks of a valid frame |
| adc_strobe | output | 1 | Sample strobe in the hold phase of each valid pixel |
| pix_idx | output | IDX_W | Global pixel index along the chain |

## Verification
The hardest situation to reach from the ports is the idle timeout that forces a new clearing burst. The idle count only begins after the frame in progress has drained. The bench therefore lowers `run` at random points, detects the true start of idle from the sensor clock going quiet, and then holds `run` low either well under or well over 2*P cycles with P at its minimum. It then counts the start pulses that come before the first valid line. Random integration values on both sides of the minimum period exercise the clamp and the per-frame sampling of the interval.

// File: rtl/linarr_pkg.sv
package linarr_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_INIT = 2'd1,
    ST_SCAN = 2'd2
  } seq_state_e;
endpackage

// File: rtl/linarr_period_sel.sv
module linarr_period_sel #(
  parameter int PER_W = 16,
  parameter int MIN_P = 2049
) (
  input  logic [PER_W-1:0] integ_in,
  input  logic             force_min,
  output logic [PER_W-1:0] period_out
);
  localparam logic [PER_W-1:0] MIN_V = PER_W'(MIN_P);

  always_comb begin
    if (force_min || (integ_in < MIN_V)) period_out = MIN_V;
    else                                  period_out = integ_in;
  end
endmodule

// File: rtl/linarr_frame_timer.sv
module linarr_frame_timer #(
  parameter int PER_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             active,
  input  logic             load,
  input  logic [PER_W-1:0] period_in,
  output logic             phase,
  output logic [PER_W-1:0] slot,
  output logic             frame_end
);
  logic [PER_W-1:0] per_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase <= 1'b0;
      slot  <= '0;
      per_q <= '0;
    end else if (load) begin
      phase <= 1'b0;
      slot  <= '0;
      per_q <= period_in;
    end else if (active) begin
      phase <= ~phase;
      if (phase) slot <= slot + 1'b1;
    end else begin
      phase <= 1'b0;
      slot  <= '0;
    end
  end

  assign frame_end = active && phase && (slot == per_q - 1'b1);
endmodule

// File: rtl/linarr_idle_timer.sv
module linarr_idle_timer #(
  parameter int PER_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             idle,
  input  logic [PER_W-1:0] limit,
  input  logic             clear_req,
  output logic             init_req
);
  localparam int CNT_W = PER_W + 2;

  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] thresh;

  assign thresh = {1'b0, limit, 1'b0};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (!idle) begin
      cnt <= '0;
    end else if (cnt != {CNT_W{1'b1}}) begin
      cnt <= cnt + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      init_req <= 1'b1;
    end else if (idle && (cnt >= thresh)) begin
      init_req <= 1'b1;
    end else if (clear_req) begin
      init_req <= 1'b0;
    end
  end
endmodule

// File: rtl/linarr_chain_readout.sv
module linarr_chain_readout
  import linarr_pkg::*;
#(
  parameter int N_DEV       = 4,
  parameter int PIX_PER_DEV = 512,
  parameter int INIT_FRAMES = 12,
  parameter int INTEG_W     = 16,
  localparam int NPIX       = N_DEV * PIX_PER_DEV,
  localparam int IDX_W      = $clog2(NPIX)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               run,
  input  logic [INTEG_W-1:0] integ_period,
  output logic               sns_clk,
  output logic               sns_start,
  output logic               frame_valid,
  output logic               adc_strobe,
  output logic [IDX_W-1:0]   pix_idx
);
  localparam int MIN_P = NPIX + 1;
  localparam int CNT_W = 4;

  generate
    if (INIT_FRAMES < 12 || INIT_FRAMES > 15) begin : g_bad_init
      $error("INIT_FRAMES must lie in 12..15");
    end
  endgenerate

  seq_state_e st, st_n;
  logic [CNT_W-1:0] init_cnt, init_cnt_n;
  logic             load, use_min, clr_init;
  logic             active, phase, frame_end, init_req;
  logic [INTEG_W-1:0] period, slot;

  assign active = (st != ST_IDLE);

  linarr_period_sel #(.PER_W(INTEG_W), .MIN_P(MIN_P)) u_psel (
    .integ_in  (integ_period),
    .force_min (use_min),
    .period_out(period)
  );

  linarr_frame_timer #(.PER_W(INTEG_W)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .active   (active),
    .load     (load),
    .period_in(period),
    .phase    (phase),
    .slot     (slot),
    .frame_end(frame_end)
  );

  linarr_idle_timer #(.PER_W(INTEG_W)) u_idle (
    .clk      (clk),
    .rst_n    (rst_n),
    .idle     (st == ST_IDLE),
    .limit    (period),
    .clear_req(clr_init),
    .init_req (init_req)
  );

  always_comb begin
    st_n       = st;
    init_cnt_n = init_cnt;
    load       = 1'b0;
    use_min    = 1'b0;
    clr_init   = 1'b0;
    case (st)
      ST_IDLE: begin
        if (run) begin
          load       = 1'b1;
          init_cnt_n = '0;
          if (init_req) begin
            st_n    = ST_INIT;
            use_min = 1'b1;
          end else begin
            st_n = ST_SCAN;
          end
        end
      end
      ST_INIT: begin
        if (frame_end) begin
          if (init_cnt == CNT_W'(INIT_FRAMES - 1)) begin
            clr_init = 1'b1;
            if (run) begin
              st_n = ST_SCAN;
              load = 1'b1;
            end else begin
              st_n = ST_IDLE;
            end
          end else begin
            init_cnt_n = init_cnt + 1'b1;
            load       = 1'b1;
            use_min    = 1'b1;
          end
        end
      end
      ST_SCAN: begin
        if (frame_end) begin
          if (run) load = 1'b1;
          else     st_n = ST_IDLE;
        end
      end
      default: st_n = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st       <= ST_IDLE;
      init_cnt <= '0;
    end else begin
      st       <= st_n;
      init_cnt <= init_cnt_n;
    end
  end

  assign sns_clk     = active && !phase;
  assign sns_start   = active && !phase && (slot == '0);
  assign frame_valid = (st == ST_SCAN) && (slot < INTEG_W'(NPIX));
  assign adc_strobe  = frame_valid && phase;
  assign pix_idx     = slot[IDX_W-1:0];
endmodule

// File: rtl/linarr_chain_chk.sv
module linarr_chain_chk #(
  parameter int IDX_W = 11
) (
  input logic             clk,
  input logic             rst_n,
  input logic             sns_clk,
  input logic             sns_start,
  input logic             frame_valid,
  input logic             adc_strobe,
  input logic [IDX_W-1:0] pix_idx
);
  p_clk_toggle_r2: assert property (@(posedge clk) disable iff (!rst_n)
    sns_clk |=> !sns_clk);

  p_start_high_r3: assert property (@(posedge clk) disable iff (!rst_n)
    sns_start |-> sns_clk);

  p_start_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
    sns_start |=> !sns_start);

  p_strobe_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    adc_strobe |-> (!sns_clk && frame_valid));

  p_idx_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
    adc_strobe |-> ##2 (!adc_strobe || (pix_idx == $past(pix_idx, 2) + 1'b1)));

  p_start_idx_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (sns_start && frame_valid) |-> (pix_idx == '0));

  p_valid_clocked_r2: assert property (@(posedge clk) disable iff (!rst_n)
    frame_valid |-> (sns_clk || adc_strobe));
endmodule

bind linarr_chain_readout linarr_chain_chk #(.IDX_W(IDX_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .sns_clk    (sns_clk),
  .sns_start  (sns_start),
  .frame_valid(frame_valid),
  .adc_strobe (adc_strobe),
  .pix_idx    (pix_idx)
);

// File: tb/linarr_chain_readout_test.sv
`timescale 1ns/1ps
module linarr_chain_readout_test;
  localparam int N_DEV = 3;
  localparam int PIX   = 16;
  localparam int INITF = 13;
  localparam int IW    = 10;
  localparam int NPIX  = N_DEV * PIX;
  localparam int MINP  = NPIX + 1;
  localparam int XW    = $clog2(NPIX);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic run = 1'b0;
  logic [IW-1:0] integ = '0;
  logic sns_clk, sns_start, frame_valid, adc_strobe;
  logic [XW-1:0] pix_idx;

  int checks = 0, errors = 0;
  int cyc = 0, si_cnt = 0, fv_frames = 0, strobe_cnt = 0, exp_idx = 0;
  int last_si = -1, gap = 0, gap_at_fv = 0, fv_fall = -1, si_at_fv = 0;
  int pre_strobes = 0, quiet_viol = 0;
  bit seen_fv = 0, quiet_chk = 0, fv_q = 0, done = 0;

  always #5 clk = ~clk;

  linarr_chain_readout #(.N_DEV(N_DEV), .PIX_PER_DEV(PIX), .INIT_FRAMES(INITF),
                         .INTEG_W(IW)) uut (
    .clk(clk), .rst_n(rst_n), .run(run), .integ_period(integ),
    .sns_clk(sns_clk), .sns_start(sns_start), .frame_valid(frame_valid),
    .adc_strobe(adc_strobe), .pix_idx(pix_idx));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at cycle %0d", req, act, exp, cyc);
    end
  endtask

  function automatic int eff_period(input int v);
    return (v < MINP) ? MINP : v;
  endfunction

  always @(negedge clk) if (rst_n) begin
    cyc++;
    if (sns_start) begin
      chk(sns_clk == 1'b1, "R3 start in high phase", int'(sns_clk), 1);
      if (last_si >= 0) gap = cyc - last_si;
      last_si = cyc;
      si_cnt++;
      if (fv_fall >= 0) chk(cyc - fv_fall >= 2, "R8 trailing clock", cyc - fv_fall, 2);
    end
    if (frame_valid && !fv_q) begin
      strobe_cnt = 0;
      exp_idx = 0;
      if (!seen_fv) begin
        seen_fv = 1;
        si_at_fv = si_cnt;
        gap_at_fv = gap;
      end
    end
    if (!frame_valid && fv_q) begin
      chk(strobe_cnt == NPIX, "R7 strobes per line", strobe_cnt, NPIX);
      fv_frames++;
      fv_fall = cyc;
    end
    if (adc_strobe) begin
      if (!seen_fv) pre_strobes++;
      chk(int'(pix_idx) == exp_idx, "R7 pixel index", int'(pix_idx), exp_idx);
      exp_idx++;
      strobe_cnt++;
    end
    if (quiet_chk && (sns_clk || sns_start)) quiet_viol++;
    fv_q = frame_valid;
  end

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      #1;
    end
  endtask

  task automatic clear_stats();
    si_cnt = 0; fv_frames = 0; seen_fv = 0; pre_strobes = 0;
    last_si = -1; fv_fall = -1;
  endtask

  task automatic wait_si(input int n, input string req);
    int target = si_cnt + n;
    int t = 0;
    while (si_cnt < target && t < 20000) begin tick(1); t++; end
    if (t >= 20000) chk(0, req, si_cnt, target);
  endtask

  task automatic wait_fv(input string req);
    int t = 0;
    while (!seen_fv && t < 20000) begin tick(1); t++; end
    if (t >= 20000) chk(0, req, 0, 1);
  endtask

  task automatic wait_idle();
    int lows = 0;
    int t = 0;
    while (lows < 3 && t < 20000) begin
      tick(1); t++;
      if (sns_clk) lows = 0; else lows++;
    end
    if (t >= 20000) chk(0, "R9 reach idle", 0, 1);
  endtask

  initial begin
    int p;
    int f0;
    void'($urandom(32'h5EED_0042));
    tick(10);
    chk({sns_clk, sns_start, frame_valid, adc_strobe} == 4'b0, "R1 reset outputs",
        int'({sns_clk, sns_start, frame_valid, adc_strobe}), 0);
    rst_n = 1'b1;
    quiet_chk = 1;
    tick(20);
    chk(quiet_viol == 0, "R2 idle clock low", quiet_viol, 0);
    quiet_chk = 0;

    // R1 / R5: first run after reset starts with a clearing burst
    clear_stats();
    run = 1'b1;
    wait_fv("R5 first valid line");
    chk(si_at_fv == INITF + 1, "R5 burst length", si_at_fv, INITF + 1);
    chk(gap_at_fv == 2 * MINP, "R5 burst period", gap_at_fv, 2 * MINP);
    chk(pre_strobes == 0, "R5 no strobes in burst", pre_strobes, 0);

    // R4: clamp at the minimum
    wait_si(2, "R4 min period");
    chk(gap == 2 * MINP, "R4 clamped period", gap, 2 * MINP);

    // R4: random intervals on both sides of the minimum
    for (int k = 0; k < 6; k++) begin
      if (k % 2 == 0) p = MINP + 1 + int'($urandom % 60);
      else            p = int'($urandom % MINP);
      integ = IW'(p);
      tick(int'($urandom % 40));
      wait_si(3, "R4 period");
      chk(gap == 2 * eff_period(p), "R4 period", gap, 2 * eff_period(p));
    end

    // R9 / R6: stop, short idle, restart without burst
    for (int k = 0; k < 2; k++) begin
      integ = '0;
      wait_si(2, "R9 settle");
      tick(int'($urandom % (2 * MINP)));
      run = 1'b0;
      wait_idle();
      f0 = si_cnt;
      quiet_chk = 1;
      tick(20 + int'($urandom % 50));
      chk(quiet_viol == 0, "R9 no start while idle", quiet_viol, 0);
      chk(si_cnt == f0, "R9 start count frozen", si_cnt, f0);
      chk(fv_frames == si_cnt - (k == 0 ? INITF : 0), "R9 every line completed",
          fv_frames, si_cnt - (k == 0 ? INITF : 0));
      quiet_chk = 0;
      clear_stats();
      run = 1'b1;
      wait_fv("R6 short idle line");
      chk(si_at_fv == 1, "R6 short idle no burst", si_at_fv, 1);
    end

    // R6: long idle forces a new burst
    integ = '0;
    wait_si(2, "R6 settle");
    run = 1'b0;
    wait_idle();
    tick(3 * MINP);
    clear_stats();
    run = 1'b1;
    wait_fv("R6 long idle line");
    chk(si_at_fv == INITF + 1, "R6 long idle burst", si_at_fv, INITF + 1);
    chk(pre_strobes == 0, "R5 no strobes in second burst", pre_strobes, 0);
    wait_si(2, "R7 final lines");
    run = 1'b0;
    wait_idle();

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    for (int i = 0; i < 150000; i++) begin
      @(posedge clk);
      if (done) break;
    end
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule